// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block takes one asynchronous serial line and turns it into 8-bit characters. A free-running divider produces a sample tick every `sample_div + 1` clocks, and the line is looked at sixteen times per bit period. A falling edge starts a candidate character. The candidate is kept only if the line is still low half a bit later. Data bits are taken at their centres, least significant bit first. They are followed by an optional parity bit and by a stop bit.

A 4-bit mode word sets up the frame. Bit 0 turns parity on. Bit 1 picks the parity sense: 0 is even and 1 is odd. Bit 2 holds the stop-length setting. Bit 3 selects synchronous mode, which suppresses the parity bit. The word is copied when a start edge is seen, so edits made during a character do not affect it. Each finished character appears on the data output for exactly one clock, together with a valid strobe and two error flags.

Top module: `serial_char_rx`

## Requirements
- R1: While reset is asserted, all outputs are 0. After reset, no start bit is accepted until at least one high sample of the synchronised line has been seen, so a line held low from reset yields no character.
- R2: A sample tick occurs once every `sample_div + 1` clocks. One bit period lasts 16 sample ticks.
- R3: A low sample begins a candidate start bit. The candidate is dropped, with no output, if the line is high at the 8th tick after it.
- R4: Eight data bits are sampled at their bit centres, 16 ticks apart. The first bit received lands in `rx_data[0]`.
- R5: When parity applies and `mode[1]` = 0 (even), `rx_perr` is set if the received data bits and the parity bit together contain an odd number of ones.
- R6: When parity applies and `mode[1]` = 1 (odd), `rx_perr` is set if the received data bits and the parity bit together contain an even number of ones.
- R7: A parity bit is expected only when `mode[0]` = 1 and `mode[3]` = 0. In every other case the stop bit directly follows data bit 7 and `rx_perr` stays 0.
- R8: `rx_ferr` is set when the first stop bit samples low. After that, the receiver waits for a high sample before it accepts another start.
- R9: Only the first stop bit is checked, and `mode[2]` has no effect on reception. A low line right after the first stop bit is taken as the start of the next character.
- R10: `rx_valid` is high for exactly one clock per character. `rx_data`, `rx_perr` and `rx_ferr` belong to that same clock, and both flags are 0 whenever `rx_valid` is 0.
- R11: The mode word is captured when the start edge is detected. Changes made during a character apply from the next character on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_div | input | DIV_W | Clocks per sample tick, minus one |
| mode | input | 4 | [0] parity on, [1] odd sense, [2] stop length, [3] synchronous select |
| rx_line | input | 1 | Serial input line, idle high |
| rx_data | output | DATA_W | Received character |
| rx_valid | output | 1 | One-clock character strobe |
| rx_perr | output | 1 | Parity error for this character |
| rx_ferr | output | 1 | Framing error for this character |

## Verification
A parity error and a framing error can both be found in the stop-bit sampling cycle of one character, and both must appear on the same strobe. The bench provokes this with a character that has even parity enabled, a wrong parity bit and a low stop bit. It expects a single strobe with both flags set and the correct data. It then holds the line low and expects no second strobe until the line has gone high again.

// File: rtl/rx_pkg.sv
package rx_pkg;

    // Mode word layout, bit 3 down to bit 0.
    typedef struct packed {
        logic sync_sel;
        logic two_stop;
        logic odd_sense;
        logic par_on;
    } mode_t;

    typedef enum logic [2:0] {
        S_WAIT_HI,
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } rx_state_e;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sync_d = line_i;
        end else begin : g_many
            always_comb sync_d = {sync_q[STAGES-2:0], line_i};
        end
    endgenerate

    // Reset to low: the receiver must then see a real high level first.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign line_o = sync_q[STAGES-1];
endmodule

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    // Greater-or-equal keeps the divider sane if div_i shrinks mid-count.
    always_comb begin
        tick_o = (cnt_q >= div_i);
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: with a non-zero divider, ticks never fall on adjacent clocks
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/rx_parity_chk.sv
module rx_parity_chk #(
    parameter int W = 8
) (
    input  logic [W-1:0] data_i,
    input  logic         par_i,
    input  logic         odd_i,
    output logic         err_o
);
    // Even sense: error on odd total; odd sense: error on even total.
    assign err_o = ^{data_i, par_i, odd_i};
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import rx_pkg::*;
#(
    parameter int W   = 8,
    parameter int OVS = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         line_i,
    input  mode_t        mode_i,
    output logic [W-1:0] data_o,
    output logic         valid_o,
    output logic         perr_o,
    output logic         ferr_o
);
    localparam int PH_W  = $clog2(OVS);
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [PH_W-1:0]  PH_MID  = PH_W'(OVS / 2 - 1);
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(OVS - 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(W - 1);

    typedef struct packed {
        rx_state_e        st;
        logic [PH_W-1:0]  ph;
        logic [IDX_W-1:0] idx;
        logic [W-1:0]     sh;
        logic             chk_par;
        logic             odd;
        logic             pbit;
        logic [W-1:0]     dout;
        logic             vld;
        logic             pe;
        logic             fe;
    } fsm_t;

    fsm_t q, d;
    logic par_err;

    // Stop length does not alter reception; the bit is deliberately unread.
    logic stop_len_unused;
    assign stop_len_unused = mode_i.two_stop;

    rx_parity_chk #(.W(W)) u_par (
        .data_i (q.sh),
        .par_i  (q.pbit),
        .odd_i  (q.odd),
        .err_o  (par_err)
    );

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        d.pe  = 1'b0;
        d.fe  = 1'b0;
        if (tick_i) begin
            unique case (q.st)
                S_WAIT_HI: if (line_i) d.st = S_IDLE;
                S_IDLE: if (!line_i) begin
                    d.st      = S_START;
                    d.ph      = '0;
                    d.chk_par = mode_i.par_on && !mode_i.sync_sel;
                    d.odd     = mode_i.odd_sense;
                end
                S_START: begin
                    if (q.ph == PH_MID) begin
                        d.ph  = '0;
                        d.idx = '0;
                        d.st  = line_i ? S_IDLE : S_DATA;
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
                S_DATA: begin
                    if (q.ph == PH_LAST) begin
                        d.ph = '0;
                        d.sh = {line_i, q.sh[W-1:1]};
                        if (q.idx == IDX_END) d.st = q.chk_par ? S_PAR : S_STOP;
                        else                  d.idx = q.idx + 1'b1;
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
                S_PAR: begin
                    if (q.ph == PH_LAST) begin
                        d.ph   = '0;
                        d.pbit = line_i;
                        d.st   = S_STOP;
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
                S_STOP: begin
                    if (q.ph == PH_LAST) begin
                        d.ph   = '0;
                        d.vld  = 1'b1;
                        d.dout = q.sh;
                        d.pe   = q.chk_par && par_err;
                        d.fe   = !line_i;
                        d.st   = line_i ? S_IDLE : S_WAIT_HI;
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
                default: d.st = S_WAIT_HI;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_WAIT_HI;
        end else begin
            q <= d;
        end
    end

    assign data_o  = q.dout;
    assign valid_o = q.vld;
    assign perr_o  = q.pe;
    assign ferr_o  = q.fe;

    // R1: a low line in the wait state never opens a character
    p_no_start_before_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WAIT_HI && !line_i) |=> (q.st == S_WAIT_HI));

    // R10: the strobe lasts one clock
    p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.vld |=> !q.vld);

    // R10: flags appear only together with the strobe
    p_flags_with_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !q.vld |-> (!q.pe && !q.fe));

    // R7: a character without parity never reports a parity error
    p_no_perr_unchecked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.vld && !q.chk_par) |-> !q.pe);

    // R8: a framing error leads into the wait-for-high state
    p_ferr_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.fe |-> (q.st == S_WAIT_HI));

    // R11: captured mode stays fixed while a character is in flight
    p_mode_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != S_IDLE && q.st != S_WAIT_HI) |=> ($stable(q.chk_par) && $stable(q.odd)));
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx
    import rx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int OVS      = 16,
    parameter int DIV_W    = 8,
    parameter int SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  sample_div,
    input  logic [3:0]        mode,
    input  logic              rx_line,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_perr,
    output logic              rx_ferr
);
    logic  line_s;
    logic  tick;
    mode_t mode_w;

    assign mode_w = mode_t'(mode);

    rx_line_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (rx_line),
        .line_o (line_s)
    );

    rx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (sample_div),
        .tick_o (tick)
    );

    rx_frame_fsm #(.W(DATA_W), .OVS(OVS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .line_i  (line_s),
        .mode_i  (mode_w),
        .data_o  (rx_data),
        .valid_o (rx_valid),
        .perr_o  (rx_perr),
        .ferr_o  (rx_ferr)
    );
endmodule

// File: tb/sim_serial_char_rx.sv
module sim_serial_char_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sample_div = 8'd0;
    logic [3:0] mode = 4'd0;
    logic       rx_line = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, rx_perr, rx_ferr;

    int n_run = 0, n_fail = 0;
    int n_strobe = 0, n_wide = 0, n_stray = 0;
    logic [7:0] cap_data [0:31];
    logic       cap_pe [0:31];
    logic       cap_fe [0:31];
    logic       prev_vld = 1'b0;

    always #5 clk = ~clk;

    serial_char_rx u0 (
        .clk(clk), .rst_n(rst_n), .sample_div(sample_div), .mode(mode),
        .rx_line(rx_line), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr)
    );

    // Observe outputs mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                cap_data[n_strobe % 32] = rx_data;
                cap_pe[n_strobe % 32]   = rx_perr;
                cap_fe[n_strobe % 32]   = rx_ferr;
                n_strobe++;
                if (prev_vld) n_wide++;
            end else if (rx_perr || rx_ferr) begin
                n_stray++;
            end
            prev_vld = rx_valid;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int nclk);
        rx_line = v;
        repeat (nclk) @(negedge clk);
    endtask

    function automatic int bit_clks();
        return 16 * (int'(sample_div) + 1);
    endfunction

    task automatic send_char(input logic [7:0] dv, input bit with_par,
                             input logic pbit, input logic stopv);
        hold(1'b0, bit_clks());
        for (int i = 0; i < 8; i++) hold(dv[i], bit_clks());
        if (with_par) hold(pbit, bit_clks());
        hold(stopv, bit_clks());
    endtask

    task automatic expect_char(input string req, input int base, input logic [7:0] dv,
                               input logic pe, input logic fe);
        chk({req, " strobe count"}, n_strobe, base + 1);
        chk({req, " data"}, int'(cap_data[base % 32]), int'(dv));
        chk({req, " parity flag"}, int'(cap_pe[base % 32]), int'(pe));
        chk({req, " framing flag"}, int'(cap_fe[base % 32]), int'(fe));
    endtask

    task automatic t_reset_state();
        chk("R1 data at reset", int'(rx_data), 0);
        chk("R1 valid at reset", int'(rx_valid), 0);
        chk("R1 flags at reset", int'({rx_perr, rx_ferr}), 0);
        @(negedge clk) rst_n = 1'b1;
        hold(1'b0, 40 * 16);
        chk("R1 low line after reset gives no character", n_strobe, 0);
        hold(1'b1, 32);
    endtask

    task automatic t_plain_chars();
        int b;
        mode = 4'b0000;
        b = n_strobe; send_char(8'hA5, 0, 0, 1); hold(1'b1, 40);
        expect_char("R4 lsb-first 0xA5", b, 8'hA5, 0, 0);
        b = n_strobe; send_char(8'h01, 0, 0, 1); hold(1'b1, 40);
        expect_char("R4 lsb-first 0x01", b, 8'h01, 0, 0);
    endtask

    task automatic t_even_parity();
        int b;
        mode = 4'b0001;
        b = n_strobe; send_char(8'h37, 1, ^8'h37, 1); hold(1'b1, 40);
        expect_char("R5 even good", b, 8'h37, 0, 0);
        b = n_strobe; send_char(8'h37, 1, ~^8'h37, 1); hold(1'b1, 40);
        expect_char("R5 even bad", b, 8'h37, 1, 0);
    endtask

    task automatic t_odd_parity();
        int b;
        mode = 4'b0011;
        b = n_strobe; send_char(8'hC4, 1, ~^8'hC4, 1); hold(1'b1, 40);
        expect_char("R6 odd good", b, 8'hC4, 0, 0);
        b = n_strobe; send_char(8'hC4, 1, ^8'hC4, 1); hold(1'b1, 40);
        expect_char("R6 odd bad", b, 8'hC4, 1, 0);
    endtask

    task automatic t_sync_no_parity();
        int b;
        mode = 4'b1001;
        b = n_strobe; send_char(8'h03, 0, 0, 1); hold(1'b1, 40);
        expect_char("R7 sync select drops parity bit", b, 8'h03, 0, 0);
        mode = 4'b0010;
        b = n_strobe; send_char(8'h03, 0, 0, 1); hold(1'b1, 40);
        expect_char("R7 parity off ignores sense", b, 8'h03, 0, 0);
    endtask

    task automatic t_false_start();
        int b;
        mode = 4'b0000;
        b = n_strobe;
        hold(1'b0, 4 * (int'(sample_div) + 1));
        hold(1'b1, 20 * 16);
        chk("R3 short low pulse rejected", n_strobe, b);
    endtask

    task automatic t_framing();
        int b;
        mode = 4'b0000;
        b = n_strobe; send_char(8'h5A, 0, 0, 0);
        hold(1'b0, 200);
        expect_char("R8 low stop", b, 8'h5A, 0, 1);
        chk("R8 no restart while line stays low", n_strobe, b + 1);
        hold(1'b1, 32);
        b = n_strobe; send_char(8'h33, 0, 0, 1); hold(1'b1, 40);
        expect_char("R8 recovery after high", b, 8'h33, 0, 0);
    endtask

    task automatic t_both_errors();
        int b;
        mode = 4'b0001;
        b = n_strobe; send_char(8'h96, 1, ~^8'h96, 0);
        hold(1'b0, 100);
        expect_char("R10 parity and framing together", b, 8'h96, 1, 1);
        hold(1'b1, 32);
    endtask

    task automatic t_back_to_back();
        int b;
        mode = 4'b0100;
        b = n_strobe;
        send_char(8'h81, 0, 0, 1);
        send_char(8'h7E, 0, 0, 1);
        hold(1'b1, 40);
        chk("R9 two characters with one stop between", n_strobe, b + 2);
        chk("R9 first data", int'(cap_data[b % 32]), 8'h81);
        chk("R9 second data", int'(cap_data[(b + 1) % 32]), 8'h7E);
        chk("R9 no framing error", int'({cap_fe[b % 32], cap_fe[(b + 1) % 32]}), 0);
    endtask

    task automatic t_mode_change();
        int b;
        mode = 4'b0000;
        b = n_strobe;
        hold(1'b0, bit_clks());
        for (int i = 0; i < 8; i++) begin
            if (i == 4) mode = 4'b0001;
            hold(i < 2 ? 1'b1 : 1'b0, bit_clks());
        end
        hold(1'b1, bit_clks());
        hold(1'b1, 60);
        expect_char("R11 mid-frame mode edit deferred", b, 8'h03, 0, 0);
        b = n_strobe; send_char(8'h03, 1, 1'b1, 1); hold(1'b1, 40);
        expect_char("R11 new mode on next character", b, 8'h03, 1, 0);
        mode = 4'b0000;
    endtask

    task automatic t_divider();
        int b;
        sample_div = 8'd2;
        hold(1'b1, 20);
        b = n_strobe; send_char(8'h6C, 0, 0, 1); hold(1'b1, 120);
        expect_char("R2 divided sample rate", b, 8'h6C, 0, 0);
        sample_div = 8'd0;
        hold(1'b1, 40);
    endtask

    task automatic t_strobe_shape();
        chk("R10 strobe never wider than one clock", n_wide, 0);
        chk("R10 no flag without strobe", n_stray, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset_state();
        t_plain_chars();
        t_even_parity();
        t_odd_parity();
        t_sync_no_parity();
        t_false_start();
        t_framing();
        t_both_errors();
        t_back_to_back();
        t_mode_change();
        t_divider();
        t_strobe_shape();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule